// File: doc/BRIEF.md
# Strided Vector Load Sequencer

This block carries out one strided vector load at a time. A start pulse supplies a base word address, a signed word stride, an element count and a destination vector register number. The block then walks the element addresses and sends each one to a word memory split into 16 interleaved banks. It writes each returned 64-bit word into the next element slot of the destination register.

Each bank has a single port and stays occupied for four clocks after it accepts a request. The block keeps its own countdown for every bank. It holds back the next address until the bank that address maps to is free. The stride therefore decides how often requests collide and how fast the load proceeds. Data comes back a fixed four clocks after each request, so element writes follow request order. A one-cycle done pulse follows the final element write.

Top module: `strided_vload`

## Requirements
- R1: Element i is read from word address base + i*stride, taken modulo 2^ADDR_W. The request carries bank = address[3:0] and row = address[ADDR_W-1:4].
- R2: Returned words are written to element slots 0, 1, ..., VL-1 in that order, one write per response, with the data unchanged. The register number is the one latched at start.
- R3: No bank receives a second request within 4 clocks of its previous one, counting across successive loads.
- R4: At most one request issues per clock. The first request issues in the cycle after start when its bank is free. With unit stride no stall ever occurs, so done arrives VL+5 cycles after the start cycle.
- R5: A stride that is a multiple of 16, including 0, targets one bank throughout. Requests are then 4 clocks apart and done arrives 4*VL+2 cycles after start.
- R6: The stride is two's complement, so negative strides walk downward and wrap modulo 2^ADDR_W.
- R7: A start with VL = 0 raises done in the next cycle with no memory request and no element write.
- R8: Done is high for exactly one cycle, the cycle after the last element write. Busy is high from the cycle after an accepted start until that done cycle, and is low during the done cycle.
- R9: A requested length above 64 is treated as 64.
- R10: A start pulse while busy is ignored. The running load completes exactly as if no second pulse had come.
- R11: During and right after reset, busy, done, req_valid and elem_we are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load; accepted only while busy is low |
| base_addr | input | ADDR_W (32) | Word address of element 0 |
| stride | input | ADDR_W (32) | Signed word distance between elements |
| vlen | input | VL_W (7) | Requested element count |
| dst_reg | input | VREG_W (3) | Destination vector register number |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Memory read request this cycle |
| req_bank | output | 4 | Bank index of the request |
| req_row | output | ADDR_W-4 (28) | Row within the bank |
| rsp_valid | input | 1 | Read data present, 4 clocks after its request |
| rsp_data | input | 64 | Read data word |
| elem_we | output | 1 | Element write strobe to the register file |
| elem_reg | output | VREG_W (3) | Register being written |
| elem_idx | output | 6 | Element slot being written |
| elem_data | output | 64 | Element value |

## Verification
The load is run with several strides: unit (no conflicts), 8 (two banks alternate, half rate), 16 and 0 (one bank, quarter rate), a negative stride, and a stride that wraps through the top of the address space. Comparing completion latency against an independent bank-timing model separates correct stall logic from stall logic that is too eager or too timid. Comparing every element value separates address stepping errors from write-ordering errors. Zero length, over-length, and a start pulse that arrives mid-load cover the edges of the handshake.

// File: rtl/vld_pkg.sv
// Shared types for the strided vector load sequencer.
// Assumes nothing beyond the parameters of the top module.
package vld_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2
    } vld_state_e;
endpackage

// File: rtl/vld_counter.sv
// Up-counter with synchronous clear, used for issue and write indices.
// Assumes clr and inc are never needed in the same cycle; clr wins.
module vld_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    // Count increments; reset and clear return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) value <= '0;
        else if (inc)      value <= value + W'(1);
    end
endmodule

// File: rtl/vld_addr_gen.sv
// Element address accumulator: loads the base, then adds the signed stride
// once for each issued request. Wraps modulo 2^ADDR_W.
// Assumes load and step are never high in the same cycle.
module vld_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] stride_q;

    // Hold the current address and the stride for the running load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr     <= '0;
            stride_q <= '0;
        end else if (load) begin
            addr     <= base;
            stride_q <= stride;
        end else if (step) begin
            addr     <= addr + stride_q;
        end
    end
endmodule

// File: rtl/vld_bank_timer.sv
// One countdown per memory bank. An issue to a bank occupies it for
// BUSY_CYC clocks, counting the issue cycle. Assumes one issue per clock.
module vld_bank_timer #(
    parameter int NBANK     = 16,
    parameter int BUSY_CYC  = 4,
    parameter int BANK_BITS = $clog2(NBANK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue,
    input  logic [BANK_BITS-1:0] issue_bank,
    output logic [NBANK-1:0]     bank_busy
);
    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [CNT_W-1:0] cnt;

        // Reload on an issue to this bank, otherwise run down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 cnt <= '0;
            else if (issue && issue_bank == BANK_BITS'(b)) cnt <= CNT_W'(BUSY_CYC - 1);
            else if (cnt != '0)                         cnt <= cnt - CNT_W'(1);
        end

        assign bank_busy[b] = (cnt != '0);
    end
endmodule

// File: rtl/strided_vload.sv
// Strided vector load sequencer, top level.
// Walks base + i*stride over an interleaved multi-bank memory. It issues at
// most one request per clock, and only to a bank whose countdown is zero.
// It writes responses to consecutive element slots.
// Assumes the memory answers every request exactly RSP_LAT clocks later.
module strided_vload
    import vld_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 64,
    parameter int NBANK    = 16,
    parameter int BUSY_CYC = 4,
    parameter int MAX_VL   = 64,
    parameter int VREG_W   = 3,
    localparam int BANK_BITS = $clog2(NBANK),
    localparam int ROW_W     = ADDR_W - BANK_BITS,
    localparam int VL_W      = $clog2(MAX_VL + 1),
    localparam int IDX_W     = $clog2(MAX_VL)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [ADDR_W-1:0]    stride,
    input  logic [VL_W-1:0]      vlen,
    input  logic [VREG_W-1:0]    dst_reg,
    output logic                 busy,
    output logic                 done,
    output logic                 req_valid,
    output logic [BANK_BITS-1:0] req_bank,
    output logic [ROW_W-1:0]     req_row,
    input  logic                 rsp_valid,
    input  logic [DATA_W-1:0]    rsp_data,
    output logic                 elem_we,
    output logic [VREG_W-1:0]    elem_reg,
    output logic [IDX_W-1:0]     elem_idx,
    output logic [DATA_W-1:0]    elem_data
);
    vld_state_e          state;
    logic [VL_W-1:0]     vl_q;
    logic [VL_W-1:0]     vl_eff;
    logic [VREG_W-1:0]   vreg_q;
    logic [ADDR_W-1:0]   cur_addr;
    logic [NBANK-1:0]    bank_busy;
    logic [VL_W-1:0]     iss_cnt;
    logic [VL_W-1:0]     wr_cnt;
    logic                accept;
    logic                last_issue;
    logic                last_write;

    // Clamp the requested length to the register capacity.
    assign vl_eff = (vlen > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vlen;
    assign accept = start && (state == ST_IDLE);

    // Request side: present the current address when its bank is free.
    assign req_bank   = cur_addr[BANK_BITS-1:0];
    assign req_row    = cur_addr[ADDR_W-1:BANK_BITS];
    assign req_valid  = (state == ST_ISSUE) && !bank_busy[req_bank];
    assign last_issue = (iss_cnt == vl_q - VL_W'(1));

    // Write side: responses arrive in issue order, one slot each.
    assign elem_we    = rsp_valid && (state != ST_IDLE);
    assign elem_reg   = vreg_q;
    assign elem_idx   = wr_cnt[IDX_W-1:0];
    assign elem_data  = rsp_data;
    assign last_write = elem_we && (wr_cnt == vl_q - VL_W'(1));

    assign busy = (state != ST_IDLE);

    vld_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .base   (base_addr),
        .stride (stride),
        .step   (req_valid),
        .addr   (cur_addr)
    );

    vld_bank_timer #(.NBANK(NBANK), .BUSY_CYC(BUSY_CYC), .BANK_BITS(BANK_BITS)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue      (req_valid),
        .issue_bank (req_bank),
        .bank_busy  (bank_busy)
    );

    vld_counter #(.W(VL_W)) u_iss_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (req_valid),
        .value (iss_cnt)
    );

    vld_counter #(.W(VL_W)) u_wr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (elem_we),
        .value (wr_cnt)
    );

    // Sequencing: accept, issue all elements, drain responses, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            vl_q   <= '0;
            vreg_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        vl_q   <= vl_eff;
                        vreg_q <= dst_reg;
                        if (vl_eff == '0) done  <= 1'b1;
                        else              state <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (req_valid && last_issue) state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (last_write) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vld_checker.sv
// Temporal checks on the port behaviour of strided_vload, attached by bind.
// Assumes the default bank occupancy of four clocks.
module vld_checker #(
    parameter int BANK_BITS = 4,
    parameter int IDX_W     = 6,
    parameter int VL_W      = 7
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [VL_W-1:0]      vlen,
    input logic                 busy,
    input logic                 done,
    input logic                 req_valid,
    input logic [BANK_BITS-1:0] req_bank,
    input logic                 elem_we,
    input logic [IDX_W-1:0]     elem_idx
);
    assert_bank_gap1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid, 1) |-> req_bank != $past(req_bank, 1));
    assert_bank_gap2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid, 2) |-> req_bank != $past(req_bank, 2));
    assert_bank_gap3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && $past(req_valid, 3) |-> req_bank != $past(req_bank, 3));
    assert_req_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);
    assert_write_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        elem_we && $past(elem_we) |-> elem_idx == $past(elem_idx) + IDX_W'(1));
    assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && vlen == '0 |=> done && !busy);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !req_valid && !elem_we);
    assert_start_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && vlen != '0 |=> busy);
endmodule

bind strided_vload vld_checker #(.BANK_BITS(BANK_BITS), .IDX_W(IDX_W), .VL_W(VL_W)) u_vld_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vlen      (vlen),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .elem_we   (elem_we),
    .elem_idx  (elem_idx)
);

// File: tb/tb_strided_vload.sv
module tb_strided_vload;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [31:0] stride = '0;
    logic [6:0]  vlen = '0;
    logic [2:0]  dst_reg = '0;
    logic        busy, done, req_valid, elem_we;
    logic [3:0]  req_bank;
    logic [27:0] req_row;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic [2:0]  elem_reg;
    logic [5:0]  elem_idx;
    logic [63:0] elem_data;

    int  n_chk = 0;
    int  n_err = 0;
    longint cyc = 0;

    always #2 clk = ~clk;

    strided_vload dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .stride(stride), .vlen(vlen), .dst_reg(dst_reg), .busy(busy),
        .done(done), .req_valid(req_valid), .req_bank(req_bank),
        .req_row(req_row), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .elem_we(elem_we), .elem_reg(elem_reg), .elem_idx(elem_idx),
        .elem_data(elem_data)
    );

    function automatic logic [63:0] mem_word(input logic [31:0] a);
        return {a ^ 32'hC3C3_0F0F, ~a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: fixed 4-clock read latency.
    logic        p_v [4];
    logic [31:0] p_a [4];
    always @(posedge clk) begin
        p_v[0] <= req_valid;
        p_a[0] <= {req_row, req_bank};
        for (int k = 1; k < 4; k++) begin
            p_v[k] <= p_v[k-1];
            p_a[k] <= p_a[k-1];
        end
        cyc <= cyc + 1;
    end
    initial for (int k = 0; k < 4; k++) begin p_v[k] = 1'b0; p_a[k] = '0; end
    assign rsp_valid = p_v[3];
    assign rsp_data  = mem_word(p_a[3]);

    // Monitor: bank spacing, request and write capture, done count.
    longint      last_req [16];
    int          n_req = 0;
    int          cap_n = 0;
    int          n_done = 0;
    logic [63:0] cap_data [128];
    logic [5:0]  cap_idx [128];
    logic [2:0]  cap_reg [128];
    initial for (int b = 0; b < 16; b++) last_req[b] = -100;
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            n_req++;
            check(cyc - last_req[req_bank] >= 4, "R3", "bank gap",
                  cyc - last_req[req_bank], 4);
            last_req[req_bank] = cyc;
        end
        if (rst_n && elem_we) begin
            if (cap_n < 128) begin
                cap_data[cap_n] = elem_data;
                cap_idx[cap_n]  = elem_idx;
                cap_reg[cap_n]  = elem_reg;
            end
            cap_n++;
        end
        if (rst_n && done) n_done++;
    end

    // Expected done latency from bank occupancy rules.
    function automatic longint model_latency(input logic [31:0] b, input logic [31:0] s,
                                             input int n);
        longint freeb [16];
        longint c = 0;
        logic [31:0] a;
        for (int k = 0; k < 16; k++) freeb[k] = 0;
        if (n == 0) return 1;
        for (int i = 0; i < n; i++) begin
            a = b + 32'(i) * s;
            c = (c + 1 > freeb[a[3:0]]) ? c + 1 : freeb[a[3:0]];
            freeb[a[3:0]] = c + 4;
        end
        return c + 5;
    endfunction

    task automatic pulse_start(input logic [31:0] b, input logic [31:0] s,
                               input logic [6:0] n, input logic [2:0] r);
        start = 1'b1; base_addr = b; stride = s; vlen = n; dst_reg = r;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Run one load and check data, order, register, latency.
    task automatic run_load(input string req, input logic [31:0] b,
                            input logic [31:0] s, input int n_req_len, input logic [2:0] r);
        int     n_eff;
        longint s_cyc;
        longint lat;
        int     req0;
        int     done0;
        int     bad;
        n_eff = (n_req_len > 64) ? 64 : n_req_len;
        cap_n = 0;
        req0  = n_req;
        done0 = n_done;
        s_cyc = cyc;
        pulse_start(b, s, 7'(n_req_len), r);
        lat = 0;
        while (!done && lat < 1000) begin @(negedge clk); lat = cyc - s_cyc; end
        lat = cyc - s_cyc;
        check(done, req, "done seen", done, 1);
        check(lat == model_latency(b, s, n_eff), req, "done latency", lat,
              model_latency(b, s, n_eff));
        check(cap_n == n_eff, req, "write count", cap_n, n_eff);
        check(n_req - req0 == n_eff, req, "request count", n_req - req0, n_eff);
        bad = 0;
        for (int i = 0; i < n_eff && i < cap_n; i++) begin
            if (cap_idx[i] != 6'(i) || cap_reg[i] != r ||
                cap_data[i] != mem_word(b + 32'(i) * s)) begin
                if (bad == 0)
                    $display("FAIL %s element %0d: actual=%0h/%0d expected=%0h/%0d", req, i,
                             cap_data[i], cap_idx[i], mem_word(b + 32'(i) * s), i);
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) n_err++;
        @(negedge clk);
        check(!done && !busy, req, "done single cycle", done, 0);
        check(n_done - done0 == 1, req, "done count", n_done - done0, 1);
        repeat (6) @(negedge clk);
    endtask

    task automatic test_reset();
        check(!busy && !done && !req_valid && !elem_we, "R11", "quiet in reset",
              {busy, done, req_valid, elem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !req_valid && !elem_we, "R11", "quiet after reset",
              {busy, done, req_valid, elem_we}, 0);
    endtask

    task automatic test_zero_len();
        int req0;
        int wr0;
        req0 = n_req;
        wr0  = cap_n;
        pulse_start(32'h100, 32'd1, 7'd0, 3'd2);
        check(done && !busy, "R7", "done next cycle", {done, busy}, 2);
        repeat (8) @(negedge clk);
        check(n_req == req0 && cap_n == wr0, "R7", "no access", n_req - req0, 0);
    endtask

    task automatic test_busy_start();
        int done0;
        done0 = n_done;
        cap_n = 0;
        pulse_start(32'd100, 32'd1, 7'd12, 3'd4);
        @(negedge clk);
        check(busy, "R8", "busy after start", busy, 1);
        pulse_start(32'd5000, 32'd3, 7'd3, 3'd1);
        while (!done) @(negedge clk);
        repeat (12) @(negedge clk);
        check(n_done - done0 == 1, "R10", "single done", n_done - done0, 1);
        check(cap_n == 12, "R10", "write count", cap_n, 12);
        check(cap_data[11] == mem_word(32'd111) && cap_reg[11] == 3'd4, "R10",
              "last element", cap_data[11], mem_word(32'd111));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        test_reset();
        repeat (4) @(negedge clk);
        run_load("R4", 32'h0000_0040, 32'd1, 20, 3'd1);
        run_load("R1", 32'h0000_1235, 32'd3, 17, 3'd3);
        run_load("R5", 32'h0000_0200, 32'd16, 8, 3'd5);
        run_load("R5", 32'h0000_0777, 32'd0, 6, 3'd6);
        run_load("R3", 32'h0000_0010, 32'd8, 10, 3'd0);
        run_load("R6", 32'h0000_0028, -32'sd3, 16, 3'd7);
        run_load("R6", 32'hFFFF_FFF8, 32'd5, 5, 3'd2);
        run_load("R2", 32'h0000_0300, -32'sd32, 7, 3'd3);
        test_zero_len();
        run_load("R9", 32'h0000_4000, 32'd1, 100, 3'd1);
        test_busy_start();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule